// File: doc/BRIEF.md
# I2C Target Byte Engine with Clock Stretching

This block is the byte-level half of an I2C target. A bit-level PHY beside it handles the wire. It reports five events to this block, each as a single-cycle pulse: a received address byte, a received data byte, a request for the next byte to transmit, a stop condition and a NACK from the controller. The block answers with three things: an acknowledge enable, a byte to shift out, and a request to hold SCL low.

On the local side, software or a sequencer arms a receive window with a maximum length. Each accepted byte comes out as a write strobe with its index and data. When the write phase ends, a done pulse carries the byte count. For a read, the local side loads one of two sources. The first is a single repeated preamble byte. The second is a packet of N bytes fetched by index through a combinational read port. When no transmit data is ready, the block stretches the clock until the load arrives. After a controller NACK it corrects the sent count and reports it.

Top module: `i2c_target_stretch`

## Requirements
- R1: After reset the block is idle: `ack_en` is 0, `scl_hold` is 0 and no pulse output is active. In idle, every PHY event is ignored. `rx_arm` in idle moves the block to receive-armed and sets `ack_en` to 1.
- R2: An address byte matches when bits [7:1] equal `own_addr`; bit 0 is the R/W flag (0 = write). A matching write in receive-armed starts the receive phase. A matching write in any other state is ignored, and a non-matching address is ignored in every state.
- R3: In the receive phase, a data byte is written out (`rx_wr`, `rx_wr_idx` = count so far, `rx_wr_data`) and the count increments, while the count is below the armed limit. Once the limit is reached, further bytes produce no write and `ack_en` drops to 0.
- R4: A transmit request during the receive phase pulses `rx_done` with the count, resets the count to 0, clears `ack_en` and enters transmit-armed. `scl_hold` is 1 while transmit-armed.
- R5: `tx_load` in transmit-armed enters the transmit phase and puts the first byte out on the next cycle with `scl_hold` released. `tx_load` during the receive phase, or in the same cycle as any PHY event, pulses `tx_refused` and changes nothing. In idle, receive-armed or transmit, it only presets the transmit phase, with no byte output.
- R6: In preamble mode (`tx_preamble` = 1) every transmit request sends `tx_byte` again and the sent count increments.
- R7: In packet mode, transmit requests send packet bytes at indices 0, 1, … N-1, in order, read through `tx_rd_idx`/`tx_rd_data`. The next request after N bytes, or a load with N = 0 while transmit-armed, pulses `tx_done` with the count and returns to transmit-armed.
- R8: A NACK during the transmit phase pulses `tx_done` with the sent count minus one (floor 0). It then returns to receive-armed with `ack_en` = 1. A NACK in any other state is ignored.
- R9: A stop outside idle returns to receive-armed with `ack_en` = 1 and `scl_hold` = 0, and pulses `rx_done` with the receive count, which then resets to 0.
- R10: A matching read address (R/W = 1) in receive-armed or transmit-armed enters transmit-armed and holds SCL. In the transmit phase it keeps the phase and the loaded data.
- R11: `rx_arm` sets the receive limit and clears the receive count in every state except the receive phase, where it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_addr | input | 7 | Programmed 7-bit target address |
| phy_addr_valid | input | 1 | Address byte received pulse |
| phy_addr_byte | input | 8 | Address in [7:1], R/W in [0] |
| phy_rx_valid | input | 1 | Data byte received pulse |
| phy_rx_data | input | 8 | Received data byte |
| phy_tx_req | input | 1 | PHY needs the next byte to send |
| phy_stop | input | 1 | Stop condition detected |
| phy_nack | input | 1 | Controller answered NACK |
| ack_en | output | 1 | Acknowledge incoming bytes |
| scl_hold | output | 1 | Hold SCL low |
| phy_tx_valid | output | 1 | Byte to shift out is valid |
| phy_tx_data | output | 8 | Byte to shift out |
| rx_arm | input | 1 | Arm the receive window |
| rx_max | input | CW | Receive window length |
| rx_wr | output | 1 | Received byte strobe |
| rx_wr_idx | output | CW | Index of the received byte |
| rx_wr_data | output | 8 | Received byte |
| rx_done | output | 1 | Receive phase ended |
| rx_count | output | CW | Bytes received in that phase |
| tx_load | input | 1 | Load transmit data |
| tx_preamble | input | 1 | 1 = repeated single byte, 0 = packet |
| tx_len | input | CW | Packet length N |
| tx_byte | input | 8 | Preamble byte |
| tx_rd_idx | output | CW | Packet byte index requested |
| tx_rd_data | input | 8 | Packet byte at `tx_rd_idx` |
| tx_refused | output | 1 | Load refused as busy |
| tx_done | output | 1 | Transmit phase ended |
| tx_sent | output | CW | Bytes actually sent |

## Verification
Every pulse output and every change of `ack_en` and `scl_hold` is registered. Each therefore appears exactly one clock edge after the PHY event or local request that causes it. The driver raises each stimulus at a falling edge for one cycle and, before that, queues the pulse it expects. The monitor compares pulses at the next falling edge, and level checks of `ack_en` and `scl_hold` run at that same edge. Any pulse that arrives with nothing queued, such as a write after overflow or a byte after a refused load, is reported as a failure. Items still queued at the end are failures too.

// File: rtl/i2c_target_stretch.sv
module i2c_target_stretch #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    own_addr,
  input  logic          phy_addr_valid,
  input  logic [7:0]    phy_addr_byte,
  input  logic          phy_rx_valid,
  input  logic [7:0]    phy_rx_data,
  input  logic          phy_tx_req,
  input  logic          phy_stop,
  input  logic          phy_nack,
  output logic          ack_en,
  output logic          scl_hold,
  output logic          phy_tx_valid,
  output logic [7:0]    phy_tx_data,
  input  logic          rx_arm,
  input  logic [CW-1:0] rx_max,
  output logic          rx_wr,
  output logic [CW-1:0] rx_wr_idx,
  output logic [7:0]    rx_wr_data,
  output logic          rx_done,
  output logic [CW-1:0] rx_count,
  input  logic          tx_load,
  input  logic          tx_preamble,
  input  logic [CW-1:0] tx_len,
  input  logic [7:0]    tx_byte,
  output logic [CW-1:0] tx_rd_idx,
  input  logic [7:0]    tx_rd_data,
  output logic          tx_refused,
  output logic          tx_done,
  output logic [CW-1:0] tx_sent
);

  typedef enum logic [2:0] {S_IDLE, S_RX_ARMED, S_RX, S_TX_ARMED, S_TX} st_t;

  st_t           state_q;
  logic [CW-1:0] rx_lim_q, rx_cnt_q, tx_len_q, tx_cnt_q;
  logic          tx_pre_q;
  logic [7:0]    tx_byte_q;

  wire phy_evt  = phy_addr_valid | phy_rx_valid | phy_tx_req | phy_stop | phy_nack;
  wire addr_hit = phy_addr_valid && (phy_addr_byte[7:1] == own_addr);
  wire load_now = tx_load && !phy_evt && (state_q == S_TX_ARMED);

  wire [CW-1:0] cnt_base = load_now ? '0 : tx_cnt_q;
  wire          mode_pre = load_now ? tx_preamble : tx_pre_q;
  wire [CW-1:0] len_sel  = load_now ? tx_len : tx_len_q;
  wire          snd_have = mode_pre || (cnt_base < len_sel);
  wire [7:0]    snd_byte = mode_pre ? (load_now ? tx_byte : tx_byte_q) : tx_rd_data;

  assign tx_rd_idx = cnt_base;
  assign scl_hold  = (state_q == S_TX_ARMED);

  always_ff @(posedge clk) begin
    rx_wr        <= 1'b0;
    rx_done      <= 1'b0;
    phy_tx_valid <= 1'b0;
    tx_done      <= 1'b0;
    tx_refused   <= 1'b0;
    if (!rst_n) begin
      state_q     <= S_IDLE;
      ack_en      <= 1'b0;
      rx_lim_q    <= '0;
      rx_cnt_q    <= '0;
      tx_len_q    <= '0;
      tx_cnt_q    <= '0;
      tx_pre_q    <= 1'b0;
      tx_byte_q   <= '0;
      rx_wr_idx   <= '0;
      rx_wr_data  <= '0;
      rx_count    <= '0;
      phy_tx_data <= '0;
      tx_sent     <= '0;
    end else begin
      if (phy_stop) begin
        if (state_q != S_IDLE) begin
          state_q  <= S_RX_ARMED;
          ack_en   <= 1'b1;
          rx_done  <= 1'b1;
          rx_count <= rx_cnt_q;
          rx_cnt_q <= '0;
        end
      end else if (phy_nack) begin
        if (state_q == S_TX) begin
          state_q <= S_RX_ARMED;
          ack_en  <= 1'b1;
          tx_done <= 1'b1;
          tx_sent <= (tx_cnt_q == '0) ? '0 : tx_cnt_q - 1'b1;
        end
      end else if (addr_hit) begin
        if (!phy_addr_byte[0]) begin
          if (state_q == S_RX_ARMED) state_q <= S_RX;
        end else if (state_q == S_RX_ARMED || state_q == S_TX_ARMED) begin
          state_q <= S_TX_ARMED;
        end
      end else if (phy_rx_valid && state_q == S_RX) begin
        if (rx_cnt_q < rx_lim_q) begin
          rx_wr      <= 1'b1;
          rx_wr_idx  <= rx_cnt_q;
          rx_wr_data <= phy_rx_data;
          rx_cnt_q   <= rx_cnt_q + 1'b1;
        end else begin
          ack_en <= 1'b0;
        end
      end else if (phy_tx_req) begin
        if (state_q == S_RX) begin
          rx_done  <= 1'b1;
          rx_count <= rx_cnt_q;
          rx_cnt_q <= '0;
          ack_en   <= 1'b0;
          state_q  <= S_TX_ARMED;
        end else if (state_q == S_TX) begin
          if (snd_have) begin
            phy_tx_valid <= 1'b1;
            phy_tx_data  <= snd_byte;
            tx_cnt_q     <= tx_cnt_q + 1'b1;
          end else begin
            state_q <= S_TX_ARMED;
            tx_done <= 1'b1;
            tx_sent <= tx_cnt_q;
          end
        end
      end

      if (tx_load) begin
        if (phy_evt || state_q == S_RX) begin
          tx_refused <= 1'b1;
        end else begin
          tx_pre_q  <= tx_preamble;
          tx_len_q  <= tx_len;
          tx_byte_q <= tx_byte;
          if (load_now) begin
            if (snd_have) begin
              phy_tx_valid <= 1'b1;
              phy_tx_data  <= snd_byte;
              tx_cnt_q     <= 1;
              state_q      <= S_TX;
            end else begin
              tx_cnt_q <= '0;
              tx_done  <= 1'b1;
              tx_sent  <= '0;
            end
          end else begin
            tx_cnt_q <= '0;
            state_q  <= S_TX;
          end
        end
      end

      if (rx_arm && state_q != S_RX) begin
        rx_lim_q <= rx_max;
        rx_cnt_q <= '0;
        if (state_q == S_IDLE && !tx_load) begin
          state_q <= S_RX_ARMED;
          ack_en  <= 1'b1;
        end
      end
    end
  end

  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> $past(phy_tx_req || phy_addr_valid)); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr |-> (rx_wr_idx < rx_lim_q)); // R3

  AST_TX_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    phy_tx_valid |-> !scl_hold); // R5

  AST_STOP_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phy_stop && state_q != S_IDLE) |-> (ack_en && !scl_hold && rx_cnt_q == '0)); // R9

  AST_NACK_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(phy_nack && !phy_stop && state_q == S_TX) |-> (ack_en && tx_done)); // R8

endmodule

// File: tb/i2c_target_stretch_test.sv
module i2c_target_stretch_test;
  localparam int CW = 8;
  localparam logic [6:0] OWN = 7'h42;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] own_addr = OWN;
  logic phy_addr_valid = 0, phy_rx_valid = 0, phy_tx_req = 0, phy_stop = 0, phy_nack = 0;
  logic [7:0] phy_addr_byte = 0, phy_rx_data = 0;
  logic ack_en, scl_hold, phy_tx_valid;
  logic [7:0] phy_tx_data;
  logic rx_arm = 0;
  logic [CW-1:0] rx_max = 0;
  logic rx_wr, rx_done;
  logic [CW-1:0] rx_wr_idx, rx_count;
  logic [7:0] rx_wr_data;
  logic tx_load = 0, tx_preamble = 0;
  logic [CW-1:0] tx_len = 0;
  logic [7:0] tx_byte = 0;
  logic [CW-1:0] tx_rd_idx, tx_sent;
  logic [7:0] tx_rd_data;
  logic tx_refused, tx_done;

  assign tx_rd_data = 8'h30 + tx_rd_idx;

  always #5 clk = ~clk;

  i2c_target_stretch #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .own_addr(own_addr),
    .phy_addr_valid(phy_addr_valid), .phy_addr_byte(phy_addr_byte),
    .phy_rx_valid(phy_rx_valid), .phy_rx_data(phy_rx_data),
    .phy_tx_req(phy_tx_req), .phy_stop(phy_stop), .phy_nack(phy_nack),
    .ack_en(ack_en), .scl_hold(scl_hold),
    .phy_tx_valid(phy_tx_valid), .phy_tx_data(phy_tx_data),
    .rx_arm(rx_arm), .rx_max(rx_max),
    .rx_wr(rx_wr), .rx_wr_idx(rx_wr_idx), .rx_wr_data(rx_wr_data),
    .rx_done(rx_done), .rx_count(rx_count),
    .tx_load(tx_load), .tx_preamble(tx_preamble), .tx_len(tx_len), .tx_byte(tx_byte),
    .tx_rd_idx(tx_rd_idx), .tx_rd_data(tx_rd_data),
    .tx_refused(tx_refused), .tx_done(tx_done), .tx_sent(tx_sent)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int unsigned exp_q[$];
  string tag_q[$];

  localparam int K_RXW = 1, K_RXD = 2, K_TXB = 3, K_TXD = 4, K_REF = 5;

  function automatic int unsigned item(int k, int v);
    return (k << 16) | (v & 16'hFFFF);
  endfunction

  task automatic expect_item(int k, int v, string tag);
    exp_q.push_back(item(k, v));
    tag_q.push_back(tag);
  endtask

  task automatic got(int k, int v);
    int unsigned e;
    string t;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL unexpected pulse: actual %08h expected none", item(k, v));
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e != item(k, v)) begin
        errors++;
        $display("FAIL %s: actual %08h expected %08h", t, item(k, v), e);
      end
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    if (rx_wr)        got(K_RXW, {rx_wr_idx, rx_wr_data});
    if (rx_done)      got(K_RXD, rx_count);
    if (phy_tx_valid) got(K_TXB, phy_tx_data);
    if (tx_done)      got(K_TXD, tx_sent);
    if (tx_refused)   got(K_REF, 0);
  end

  task automatic lvl(string tag, logic a, logic h, logic ea, logic eh);
    checks++;
    if (a !== ea || h !== eh) begin
      errors++;
      $display("FAIL %s: actual ack=%0b hold=%0b expected ack=%0b hold=%0b", tag, a, h, ea, eh);
    end
  endtask

  task automatic addr(logic [6:0] a, logic rw);
    @(negedge clk); phy_addr_valid = 1; phy_addr_byte = {a, rw};
    @(negedge clk); phy_addr_valid = 0;
  endtask
  task automatic rxb(logic [7:0] d);
    @(negedge clk); phy_rx_valid = 1; phy_rx_data = d;
    @(negedge clk); phy_rx_valid = 0;
  endtask
  task automatic treq;
    @(negedge clk); phy_tx_req = 1;
    @(negedge clk); phy_tx_req = 0;
  endtask
  task automatic stop;
    @(negedge clk); phy_stop = 1;
    @(negedge clk); phy_stop = 0;
  endtask
  task automatic nack;
    @(negedge clk); phy_nack = 1;
    @(negedge clk); phy_nack = 0;
  endtask
  task automatic load(logic pre, int len, logic [7:0] b);
    @(negedge clk); tx_load = 1; tx_preamble = pre; tx_len = len[CW-1:0]; tx_byte = b;
    @(negedge clk); tx_load = 0;
  endtask
  task automatic arm(int m);
    @(negedge clk); rx_arm = 1; rx_max = m[CW-1:0];
    @(negedge clk); rx_arm = 0;
  endtask

  task automatic finish_run;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    lvl("R1 reset", ack_en, scl_hold, 0, 0);
    stop();                                   // R9 stop in idle ignored
    addr(OWN, 0); rxb(8'h11);                 // R1 idle ignores PHY
    lvl("R1 idle ignores events", ack_en, scl_hold, 0, 0);
    arm(3);
    lvl("R11 arm from idle", ack_en, scl_hold, 1, 0);

    addr(7'h13, 0); rxb(8'h99);               // R2 non-matching ignored
    addr(OWN, 0);
    expect_item(K_RXW, {8'd0, 8'hA1}, "R3 byte0"); rxb(8'hA1);
    expect_item(K_RXW, {8'd1, 8'hA2}, "R3 byte1"); rxb(8'hA2);
    expect_item(K_RXW, {8'd2, 8'hA3}, "R3 byte2"); rxb(8'hA3);
    lvl("R3 ack before overflow", ack_en, scl_hold, 1, 0);
    rxb(8'hA4);
    lvl("R3 overflow nack", ack_en, scl_hold, 0, 0);
    expect_item(K_RXD, 3, "R9 stop count"); stop();
    lvl("R9 stop rearm", ack_en, scl_hold, 1, 0);

    addr(OWN, 0);
    expect_item(K_RXW, {8'd0, 8'h55}, "R3 byte after rearm"); rxb(8'h55);
    expect_item(K_REF, 0, "R5 load in rx refused"); load(0, 3, 8'h00);
    expect_item(K_RXD, 1, "R4 rx done count"); treq();
    lvl("R4 turnaround hold", ack_en, scl_hold, 0, 1);

    expect_item(K_TXB, 8'h30, "R5 first byte on load"); load(0, 3, 8'h00);
    lvl("R5 hold released", ack_en, scl_hold, 0, 0);
    expect_item(K_TXB, 8'h31, "R7 packet byte1"); treq();
    expect_item(K_TXB, 8'h32, "R7 packet byte2"); treq();
    expect_item(K_TXD, 3, "R7 packet done"); treq();
    lvl("R7 back to armed", ack_en, scl_hold, 0, 1);

    expect_item(K_TXB, 8'h5A, "R6 preamble first"); load(1, 0, 8'h5A);
    expect_item(K_TXB, 8'h5A, "R6 preamble repeat"); treq();
    expect_item(K_TXB, 8'h5A, "R6 preamble repeat2"); treq();
    expect_item(K_TXD, 2, "R8 nack count minus one"); nack();
    lvl("R8 nack rearm", ack_en, scl_hold, 1, 0);

    load(0, 2, 8'h00);                         // R5 preset, no output
    lvl("R5 preset no hold", ack_en, scl_hold, 1, 0);
    addr(OWN, 0); rxb(8'h77);                  // R2 write ignored in TX
    addr(OWN, 1);                              // R10 stays TX
    lvl("R10 read in tx no hold", ack_en, scl_hold, 1, 0);
    expect_item(K_TXB, 8'h30, "R10 preset byte0"); treq();
    expect_item(K_TXB, 8'h31, "R10 preset byte1"); treq();
    expect_item(K_TXD, 1, "R8 nack after two"); nack();

    addr(OWN, 1);
    lvl("R10 read holds", ack_en, scl_hold, 1, 1);
    expect_item(K_RXD, 0, "R9 stop from tx armed"); stop();
    lvl("R9 hold released", ack_en, scl_hold, 1, 0);

    expect_item(K_RXD, 0, "R9 collision stop");
    expect_item(K_REF, 0, "R5 collision refused");
    @(negedge clk); phy_stop = 1; tx_load = 1; tx_preamble = 1; tx_byte = 8'hEE;
    @(negedge clk); phy_stop = 0; tx_load = 0;
    addr(OWN, 0);                              // still receive-armed: enters RX
    arm(1);                                    // R11 ignored in RX
    expect_item(K_RXW, {8'd0, 8'hC0}, "R11 limit kept b0"); rxb(8'hC0);
    expect_item(K_RXW, {8'd1, 8'hC1}, "R11 limit kept b1"); rxb(8'hC1);
    expect_item(K_RXD, 2, "R11 count"); stop();

    addr(OWN, 1);
    expect_item(K_TXD, 0, "R7 zero-length packet"); load(0, 0, 8'h00);
    lvl("R7 zero-length keeps hold", ack_en, scl_hold, 1, 1);
    nack();                                    // R8 ignored outside TX
    lvl("R8 nack ignored", ack_en, scl_hold, 1, 1);
    expect_item(K_RXD, 0, "R9 final stop"); stop();

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL missing pulses: actual %0d left expected 0 (first %s)", exp_q.size(), tag_q[0]);
    end
    finish_run();
  end
endmodule